// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Register Core

This block is the digital control core of a multi-channel, parallel-load voltage-output converter. A host drives a parallel bus with a channel address, a 12-bit code and two per-channel control bits: a gain select and a reference-buffer enable. Writes are qualified by an active-low select and an active-low write strobe. Each channel has two register stages. A write lands in the staging stage. The active-low load input moves staged words into the output stage, which feeds the converter.

When the load input is held high, the host can stage any number of channels and then release all of them in one step. When the load input is held low, every write flows through to its output shortly after the write strobe rises. A channel's output stage is refreshed only when its staging stage has been written since its last transfer. A per-channel pending flag tracks this.

The host can read back an output word over the bus. An asynchronous clear zeroes every register. A power-down input marks every channel output as high-impedance and keeps the register contents. All host strobes pass through two-flop synchronizers into the system clock domain.

Top module: `dac_dbuf_core`

## Requirements
- R1: A word `{gain_sel, buf_sel, data_in}` is captured into the staging stage of the channel named by `addr` when the synchronized `wr_n` rises while the synchronized `cs_n` is low. A write strobe with `cs_n` high changes no register.
- R2: While `ldac_n` is high, the output stage of every channel holds its value, whatever is written to the staging stages.
- R3: While `ldac_n` is low, each channel with a pending write copies its staging word into its output stage. A pulse low on `ldac_n` updates all such channels in the same clock cycle.
- R4: The gain and buffer bits are double-buffered with the code. `dac_gain[i]` and `dac_bufen[i]` change only when channel i transfers.
- R5: Only channels written since their last transfer are updated. A write sets the channel's pending flag and a transfer clears it. Channels without a pending flag keep their output. When a channel is written twice before a load, the last write wins.
- R6: `clr_n` low asynchronously zeroes the staging stages, output stages and pending flags of all channels. No clock edge is needed.
- R7: After `rst_n` is released, all outputs are zero, `rd_oe` is low and `out_hiz` is all zeros. The outputs stay zero until a valid write and transfer occur.
- R8: With `ldac_n` held low, a write reaches the addressed channel's outputs within six clock cycles of `wr_n` rising.
- R9: A falling synchronized `rd_n` while `cs_n` is low latches the output word of channel `addr` onto `rd_data`, laid out as bit 13 gain, bit 12 buffer, bits 11:0 code, and raises `rd_oe`. `rd_oe` falls once `rd_n` or `cs_n` is high.
- R10: While `pd_n` is low, `out_hiz` is all ones. Register contents are kept and reappear unchanged when `pd_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| clr_n | input | 1 | Active-low asynchronous register clear |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe, acts on its rising edge |
| rd_n | input | 1 | Active-low read strobe, acts on its falling edge |
| ldac_n | input | 1 | Active-low load (transfer) control |
| pd_n | input | 1 | Active-low power-down |
| addr | input | 3 | Channel address |
| data_in | input | 12 | Code to write |
| gain_sel | input | 1 | Gain bit to write |
| buf_sel | input | 1 | Buffer-enable bit to write |
| dac_code | output | 96 | Output-stage codes, channel i at bits 12*i+11:12*i |
| dac_gain | output | 8 | Output-stage gain bits |
| dac_bufen | output | 8 | Output-stage buffer bits |
| out_hiz | output | 8 | Per-channel high-impedance flag |
| rd_data | output | 14 | Readback word |
| rd_oe | output | 1 | Bus drive enable for readback |

## Verification
The bench stages writes with the load input high and checks that nothing moves. A design that treated load as edge-free, or that let staging flow through, would show the new code early. It then pulses load and checks that written channels update together while untouched channels keep their values. This exposes a design that refreshes every channel or misses the pending flag. A write with select high, two writes before one load, a readback of each layout field, a power-down round trip, and a clear applied without any clock edge cover the remaining corners. Each of these catches a design that lets the stray write in, keeps the first word, swaps the gain and buffer bits, loses contents in power-down, or waits for a clock to clear.

// File: rtl/dac_core_pkg.sv
package dac_core_pkg;
  localparam int CODE_W   = 12;
  localparam int NUM_CH   = 8;
  localparam int N_STROBE = 5;

  typedef struct packed {
    logic              gain;
    logic              bufen;
    logic [CODE_W-1:0] code;
  } chan_word_t;

  localparam int WORD_W = $bits(chan_word_t);
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  chan_word_t wr_word,
  input  logic       ld_low,
  output chan_word_t out_word,
  output logic       pending
);
  chan_word_t stage_q, stage_d, out_q, out_d;
  logic       pend_q, pend_d, xfer;

  always_comb begin
    xfer    = ld_low && pend_q;
    stage_d = wr_hit ? wr_word : stage_q;
    out_d   = xfer ? stage_q : out_q;
    if (wr_hit)    pend_d = 1'b1;
    else if (xfer) pend_d = 1'b0;
    else           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      out_q   <= out_d;
      pend_q  <= pend_d;
    end
  end

  assign out_word = out_q;
  assign pending  = pend_q;

  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (stage_q == $past(wr_word)));                              // R1
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_low |=> $stable(out_q));                                          // R2
  AST_HOLD_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(out_q));                                          // R5
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ld_low && !wr_hit) |=> (!pend_q && out_q == $past(stage_q))); // R3
endmodule

// File: rtl/dac_rdback.sv
module dac_rdback
  import dac_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_start,
  input  logic       bus_idle,
  input  chan_word_t sel_word,
  output chan_word_t rd_word,
  output logic       rd_oe
);
  chan_word_t word_q, word_d;
  logic       oe_q, oe_d;

  always_comb begin
    word_d = rd_start ? sel_word : word_q;
    if (rd_start)      oe_d = 1'b1;
    else if (bus_idle) oe_d = 1'b0;
    else               oe_d = oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      oe_q   <= oe_d;
    end
  end

  assign rd_word = word_q;
  assign rd_oe   = oe_q;

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> !rd_oe);                                                 // R9
  AST_RD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (rd_oe && rd_word == $past(sel_word)));                  // R9
endmodule

// File: rtl/dac_dbuf_core.sv
module dac_dbuf_core
  import dac_core_pkg::*;
#(
  parameter int NCH    = NUM_CH,
  parameter int DW     = CODE_W,
  localparam int AW    = $clog2(NCH),
  localparam int RDW   = DW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ldac_n,
  input  logic              pd_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data_in,
  input  logic              gain_sel,
  input  logic              buf_sel,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    dac_gain,
  output logic [NCH-1:0]    dac_bufen,
  output logic [NCH-1:0]    out_hiz,
  output logic [RDW-1:0]    rd_data,
  output logic              rd_oe
);
  logic sys_rst_n, reg_rst_n;
  logic [N_STROBE-1:0] strb_raw, strb_s;
  logic cs_s, wr_s, rd_s, ld_s, pd_s;
  logic wr_prev_q, rd_prev_q, wr_rise, rd_fall;
  chan_word_t wr_word, sel_word, rd_word;
  chan_word_t out_words [NCH];
  logic [NCH-1:0] pend_vec;

  dac_rst_sync u_sys_rst (.clk(clk), .arst_n(rst_n),         .srst_n(sys_rst_n));
  dac_rst_sync u_reg_rst (.clk(clk), .arst_n(rst_n && clr_n), .srst_n(reg_rst_n));

  assign strb_raw = {pd_n, ldac_n, rd_n, wr_n, cs_n};

  dac_sync #(.W(N_STROBE), .RST_VAL({N_STROBE{1'b1}})) u_strb_sync (
    .clk(clk), .rst_n(sys_rst_n), .din(strb_raw), .dout(strb_s));

  assign {pd_s, ld_s, rd_s, wr_s, cs_s} = strb_s;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= wr_s;
      rd_prev_q <= rd_s;
    end
  end

  assign wr_rise = wr_s && !wr_prev_q;
  assign rd_fall = !rd_s && rd_prev_q;

  always_comb begin
    wr_word.gain  = gain_sel;
    wr_word.bufen = buf_sel;
    wr_word.code  = data_in;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic hit;
    assign hit = wr_rise && !cs_s && (addr == AW'(i));
    dac_chan u_chan (
      .clk(clk), .rst_n(reg_rst_n), .wr_hit(hit), .wr_word(wr_word),
      .ld_low(!ld_s), .out_word(out_words[i]), .pending(pend_vec[i]));
    assign dac_code[i*DW +: DW] = out_words[i].code;
    assign dac_gain[i]          = out_words[i].gain;
    assign dac_bufen[i]         = out_words[i].bufen;
    assign out_hiz[i]           = !pd_s;
  end

  assign sel_word = out_words[addr];

  dac_rdback u_rdback (
    .clk(clk), .rst_n(reg_rst_n), .rd_start(rd_fall && !cs_s),
    .bus_idle(rd_s || cs_s), .sel_word(sel_word),
    .rd_word(rd_word), .rd_oe(rd_oe));

  assign rd_data = rd_word;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_code == '0 && dac_gain == '0 && dac_bufen == '0 && pend_vec == '0)); // R6
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!reg_rst_n)
    (cs_s && (pend_vec == '0)) |=> (pend_vec == '0));                      // R1
endmodule

// File: tb/dac_dbuf_core_test.sv
module dac_dbuf_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 12;

  typedef struct {
    int          kind;   // 0: channel word, 1: {oe, bus}, 2: hiz vector
    int          ch;
    logic [15:0] exp;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, clr_n, cs_n, wr_n, rd_n, ldac_n, pd_n;
  logic [2:0] addr;
  logic [DW-1:0] data_in;
  logic gain_sel, buf_sel;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0] dac_gain, dac_bufen, out_hiz;
  logic [DW+1:0] rd_data;
  logic rd_oe;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t sb_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_core uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .rd_n(rd_n), .ldac_n(ldac_n), .pd_n(pd_n), .addr(addr), .data_in(data_in),
    .gain_sel(gain_sel), .buf_sel(buf_sel), .dac_code(dac_code),
    .dac_gain(dac_gain), .dac_bufen(dac_bufen), .out_hiz(out_hiz),
    .rd_data(rd_data), .rd_oe(rd_oe));

  function automatic logic [15:0] observe(int kind, int ch);
    case (kind)
      0: return {2'b00, dac_gain[ch], dac_bufen[ch], dac_code[ch*DW +: DW]};
      1: return {1'b0, rd_oe, rd_data};
      default: return {8'h00, out_hiz};
    endcase
  endfunction

  function automatic void compare(exp_t it);
    logic [15:0] act;
    act = observe(it.kind, it.ch);
    n_tests++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s kind=%0d ch=%0d actual=%h expected=%h", it.req, it.kind, it.ch, act, it.exp);
    end
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) compare(sb_q.pop_front());
    end
  end

  task automatic expect_item(int kind, int ch, logic [15:0] exp, string req);
    exp_t it;
    it.kind = kind; it.ch = ch; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    @(posedge clk);
  endtask

  task automatic expect_ch(int ch, logic g, logic b, logic [DW-1:0] c, string req);
    expect_item(0, ch, {2'b00, g, b, c}, req);
  endtask

  task automatic host_write(int ch, logic [DW-1:0] c, logic g, logic b, bit sel);
    @(negedge clk);
    addr = 3'(ch); data_in = c; gain_sel = g; buf_sel = b; cs_n = !sel;
    repeat (3) @(negedge clk);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    ldac_n = 1'b0;
    repeat (5) @(negedge clk);
    ldac_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic host_read(int ch, logic [DW+1:0] exp, string req);
    @(negedge clk);
    addr = 3'(ch); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b0;
    repeat (6) @(negedge clk);
    expect_item(1, ch, {2'b01, exp}, req);
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_item(1, ch, {2'b00, exp}, {req, " release"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    ldac_n = 1'b1; pd_n = 1'b1; addr = '0; data_in = '0; gain_sel = 1'b0; buf_sel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R7: reset state
    for (int i = 0; i < NCH; i++) expect_ch(i, 1'b0, 1'b0, '0, "R7 reset zero");
    expect_item(1, 0, 16'h0000, "R7 bus idle");
    expect_item(2, 0, 16'h0000, "R7 hiz clear");

    // R2: staged write does not reach the output while load is high
    host_write(3, 12'hABC, 1'b1, 1'b0, 1'b1);
    expect_ch(3, 1'b0, 1'b0, 12'h000, "R2 hold while load high");
    // R3 R4: load pulse transfers code and gain
    pulse_load();
    expect_ch(3, 1'b1, 1'b0, 12'hABC, "R3 R4 transfer on load");
    expect_ch(0, 1'b0, 1'b0, 12'h000, "R5 untouched channel");

    // R1: write with select high is ignored; R5: last of two writes wins
    host_write(5, 12'h555, 1'b1, 1'b1, 1'b0);
    host_write(3, 12'h123, 1'b0, 1'b1, 1'b1);
    host_write(3, 12'h456, 1'b0, 1'b1, 1'b1);
    host_write(6, 12'h0F0, 1'b1, 1'b1, 1'b1);
    expect_ch(3, 1'b1, 1'b0, 12'hABC, "R2 hold second stage");
    pulse_load();
    expect_ch(5, 1'b0, 1'b0, 12'h000, "R1 deselected write ignored");
    expect_ch(3, 1'b0, 1'b1, 12'h456, "R5 last write wins");
    expect_ch(6, 1'b1, 1'b1, 12'h0F0, "R3 simultaneous update");
    expect_ch(0, 1'b0, 1'b0, 12'h000, "R5 unwritten kept");

    // R8: synchronous mode with load held low
    @(negedge clk); ldac_n = 1'b0;
    host_write(7, 12'hFFF, 1'b1, 1'b1, 1'b1);
    expect_ch(7, 1'b1, 1'b1, 12'hFFF, "R8 flow-through write");
    host_write(1, 12'h001, 1'b0, 1'b0, 1'b1);
    expect_ch(1, 1'b0, 1'b0, 12'h001, "R8 second flow-through");
    expect_ch(6, 1'b1, 1'b1, 12'h0F0, "R5 neighbour kept in sync mode");
    @(negedge clk); ldac_n = 1'b1;

    // R9: readback, layout bit13 gain, bit12 buffer, bits 11:0 code
    host_read(7, {1'b1, 1'b1, 12'hFFF}, "R9 readback ch7");
    host_read(3, {1'b0, 1'b1, 12'h456}, "R9 readback ch3");
    host_read(6, {1'b1, 1'b1, 12'h0F0}, "R9 readback ch6");

    // R10: power-down
    @(negedge clk); pd_n = 1'b0;
    repeat (5) @(negedge clk);
    expect_item(2, 0, 16'h00FF, "R10 all hiz");
    expect_ch(7, 1'b1, 1'b1, 12'hFFF, "R10 contents kept");
    @(negedge clk); pd_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_item(2, 0, 16'h0000, "R10 hiz released");
    expect_ch(3, 1'b0, 1'b1, 12'h456, "R10 contents after power-up");

    // R6: asynchronous clear, checked between clock edges
    @(negedge clk);
    #(CLK_PERIOD/4) clr_n = 1'b0;
    #1;
    n_tests++;
    if (dac_code !== '0 || dac_gain !== '0 || dac_bufen !== '0) begin
      n_fail++;
      $display("FAIL R6 async clear actual=%h expected=0", dac_code);
    end
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_load();
    expect_ch(7, 1'b0, 1'b0, 12'h000, "R6 clear drops pending");
    host_write(2, 12'h321, 1'b1, 1'b0, 1'b1);
    pulse_load();
    expect_ch(2, 1'b1, 1'b0, 12'h321, "R6 write after clear");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule